// File: doc/BRIEF.md
# Four-Port Time-Division Serial Line Interface

This block lets four Ethernet ports share one narrow set of wires toward a switch. Each port keeps its own parallel signals on the port side: a transmit-enable and transmit-data pair going out, and receive-activity, receive-valid, receive-data and collision coming in. On the line side, every one of these is carried on a single wire. Each wire carries four consecutive bit-clock cycles, one per port, and the sequence repeats. All signals are serial NRZ and are timed by one shared bit clock. A strobe input sets the slot sequence: its rising edge forces the next cycle to be port 0's slot.

Port-side receive conditions go out on the shared line outputs in the matching slot. Carrier sense for a port is raised for receive activity and also while that port's transmit enable is held. Transmit enable and data from the line are steered into per-port holding registers, and each register changes only in its own port's slot.

While the block is in reset, its line outputs are released so that external strap resistors can set their levels. The pad levels of three of those pins are latched as upper PHY address bits when reset ends. The slot stream has no back-pressure: every slot is consumed or produced in its own cycle, and nothing can stall it. The line wires are therefore plain signals, not valid/ready handshakes.

Top module: `tdm_phy_mux`

## Requirements
- R1: After the clock edge at which `strb` is first sampled high (it was low at the edge before), the following cycle is port 0's slot. Slots then run port 0, 1, 2, 3 on consecutive cycles and repeat without further strobes.
- R2: A strobe rising edge in the middle of a frame immediately makes the next cycle port 0's slot. Holding `strb` high for more cycles causes no further re-alignment.
- R3: The values on `mux_tx_en` and `mux_tx_data` sampled at the clock edge that ends port k's slot are loaded into `port_tx_en[k]` and `port_tx_data[k]`. The other ports' transmit outputs keep their values.
- R4: Throughout port k's slot, `mux_rx_valid`, `mux_rx_data` and `mux_col` show `port_rx_valid[k]`, `port_rx_data[k]` and `port_col[k]` as sampled at the clock edge that begins the slot.
- R5: Throughout port k's slot, `mux_crs` shows `port_rx_act[k]` OR the held `port_tx_en[k]`, both taken at the edge that begins the slot.
- R6: Reset is synchronous and active low. While reset is active, `line_oe` is low and all four line outputs and all port transmit outputs are 0. `line_oe` goes high at the first edge with reset released.
- R7: `phy_addr_strap[2]` takes `pad_col_in`, `[3]` takes `pad_vld_in` and `[4]` takes `pad_dat_in`, as sampled at the last clock edge with reset active. The value then holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strb | input | 1 | Slot alignment strobe, rising edge selects port 0 next |
| mux_tx_en | input | 1 | Multiplexed transmit enable |
| mux_tx_data | input | 1 | Multiplexed NRZ transmit data |
| mux_crs | output | 1 | Multiplexed carrier sense |
| mux_rx_valid | output | 1 | Multiplexed receive valid |
| mux_rx_data | output | 1 | Multiplexed NRZ receive data |
| mux_col | output | 1 | Multiplexed collision |
| line_oe | output | 1 | Drive enable for the four line outputs, low in reset |
| pad_col_in | input | 1 | Pad level of the collision pin, strap for address bit 2 |
| pad_vld_in | input | 1 | Pad level of the receive-valid pin, strap for address bit 3 |
| pad_dat_in | input | 1 | Pad level of the receive-data pin, strap for address bit 4 |
| port_rx_act | input | NPORTS | Per-port receive activity |
| port_rx_valid | input | NPORTS | Per-port receive valid |
| port_rx_data | input | NPORTS | Per-port receive data |
| port_col | input | NPORTS | Per-port collision |
| port_tx_en | output | NPORTS | Per-port held transmit enable |
| port_tx_data | output | NPORTS | Per-port held transmit data |
| phy_addr_strap | output | 3 | Latched PHY address bits 4..2 |

## Verification
The first vectors drive all-zero and all-one patterns, which show that every slot carries data. Per-port patterns in which every port and every signal differ come next, and a wrong slot order or a swapped line shows up as a wrong bit. Further vectors put data on a port whose enable is low, and raise transmit enable with no receive activity, so that the carrier-sense OR is separated from a plain copy of the receive input. Directed cases place a strobe in the middle of a frame, hold the strobe high across several slots, and change the strap pads during reset and again after it.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NPORTS_DEF = 4;

  typedef struct packed {
    logic crs;
    logic valid;
    logic data;
    logic col;
  } line_rx_t;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int NPORTS = 4,
  localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] slot_next
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPORTS - 1);

  logic strb_q;
  logic strb_rise;

  // strobe history runs through reset so a level held across release is not an edge
  always_ff @(posedge clk) strb_q <= strb;

  assign strb_rise = strb & ~strb_q;

  always_comb begin
    if (strb_rise)         slot_next = '0;
    else if (slot == LAST) slot_next = '0;
    else                   slot_next = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot_next;
  end
endmodule

// File: rtl/tdm_tx_demux.sv
module tdm_tx_demux #(
  parameter int NPORTS = 4,
  localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              mux_tx_en,
  input  logic              mux_tx_data,
  output logic [NPORTS-1:0] port_tx_en,
  output logic [NPORTS-1:0] port_tx_data
);
  logic [NPORTS-1:0] slot_hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_hit
    assign slot_hit[p] = (slot == SLOT_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_tx_en   <= '0;
      port_tx_data <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (slot_hit[p]) begin
          port_tx_en[p]   <= mux_tx_en;
          port_tx_data[p] <= mux_tx_data;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_rx_mux.sv
module tdm_rx_mux import tdm_pkg::*; #(
  parameter int NPORTS = 4,
  localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_next,
  input  logic [NPORTS-1:0] port_rx_act,
  input  logic [NPORTS-1:0] port_rx_valid,
  input  logic [NPORTS-1:0] port_rx_data,
  input  logic [NPORTS-1:0] port_col,
  input  logic [NPORTS-1:0] port_tx_en,
  output line_rx_t          line_q,
  output logic              line_oe
);
  line_rx_t slot_bits [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign slot_bits[p].crs   = port_rx_act[p] | port_tx_en[p];
    assign slot_bits[p].valid = port_rx_valid[p];
    assign slot_bits[p].data  = port_rx_data[p];
    assign slot_bits[p].col   = port_col[p];
  end

  // look one slot ahead so the line pins come straight from flops
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      line_oe <= 1'b0;
    end else begin
      line_q  <= slot_bits[slot_next];
      line_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_strap_latch.sv
module tdm_strap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_col_in,
  input  logic       pad_vld_in,
  input  logic       pad_dat_in,
  output logic [4:2] phy_addr_strap
);
  // tracks the pads for as long as reset lasts, frozen once it ends
  always_ff @(posedge clk) begin
    if (!rst_n) phy_addr_strap <= {pad_dat_in, pad_vld_in, pad_col_in};
  end
endmodule

// File: rtl/tdm_phy_mux.sv
module tdm_phy_mux import tdm_pkg::*; #(
  parameter int NPORTS = NPORTS_DEF,
  localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic              mux_tx_en,
  input  logic              mux_tx_data,
  output logic              mux_crs,
  output logic              mux_rx_valid,
  output logic              mux_rx_data,
  output logic              mux_col,
  output logic              line_oe,
  input  logic              pad_col_in,
  input  logic              pad_vld_in,
  input  logic              pad_dat_in,
  input  logic [NPORTS-1:0] port_rx_act,
  input  logic [NPORTS-1:0] port_rx_valid,
  input  logic [NPORTS-1:0] port_rx_data,
  input  logic [NPORTS-1:0] port_col,
  output logic [NPORTS-1:0] port_tx_en,
  output logic [NPORTS-1:0] port_tx_data,
  output logic [4:2]        phy_addr_strap
);
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_next;
  line_rx_t          line_q;

  tdm_slot_timer #(.NPORTS(NPORTS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .slot      (slot),
    .slot_next (slot_next)
  );

  tdm_tx_demux #(.NPORTS(NPORTS)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot         (slot),
    .mux_tx_en    (mux_tx_en),
    .mux_tx_data  (mux_tx_data),
    .port_tx_en   (port_tx_en),
    .port_tx_data (port_tx_data)
  );

  tdm_rx_mux #(.NPORTS(NPORTS)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_next     (slot_next),
    .port_rx_act   (port_rx_act),
    .port_rx_valid (port_rx_valid),
    .port_rx_data  (port_rx_data),
    .port_col      (port_col),
    .port_tx_en    (port_tx_en),
    .line_q        (line_q),
    .line_oe       (line_oe)
  );

  tdm_strap_latch u_strap (
    .clk            (clk),
    .rst_n          (rst_n),
    .pad_col_in     (pad_col_in),
    .pad_vld_in     (pad_vld_in),
    .pad_dat_in     (pad_dat_in),
    .phy_addr_strap (phy_addr_strap)
  );

  assign mux_crs      = line_q.crs;
  assign mux_rx_valid = line_q.valid;
  assign mux_rx_data  = line_q.data;
  assign mux_col      = line_q.col;
endmodule

// File: rtl/tdm_phy_mux_chk.sv
module tdm_phy_mux_chk #(
  parameter int NPORTS = 4,
  localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb,
  input logic [SLOT_W-1:0] slot,
  input logic              line_oe,
  input logic              mux_crs,
  input logic              mux_rx_valid,
  input logic              mux_rx_data,
  input logic              mux_col,
  input logic [NPORTS-1:0] port_tx_en,
  input logic [NPORTS-1:0] port_tx_data,
  input logic [4:2]        phy_addr_strap
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPORTS - 1);

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;

  // R6: everything quiet after an edge taken in reset
  always @(negedge clk) begin
    if (rst_seen_q) begin
      p_quiet_in_reset_r6: assert (!line_oe && !mux_crs && !mux_rx_valid && !mux_rx_data
                                   && !mux_col && port_tx_en == '0 && port_tx_data == '0);
    end
  end

  p_drive_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> line_oe);

  p_rise_to_port0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |=> (slot == '0));

  p_slot_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(strb) |=> (slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1)));

  p_one_port_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones((port_tx_en ^ $past(port_tx_en)) |
                          (port_tx_data ^ $past(port_tx_data))) <= 1));

  p_strap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(phy_addr_strap));
endmodule

bind tdm_phy_mux tdm_phy_mux_chk #(.NPORTS(NPORTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .strb           (strb),
  .slot           (slot),
  .line_oe        (line_oe),
  .mux_crs        (mux_crs),
  .mux_rx_valid   (mux_rx_valid),
  .mux_rx_data    (mux_rx_data),
  .mux_col        (mux_col),
  .port_tx_en     (port_tx_en),
  .port_tx_data   (port_tx_data),
  .phy_addr_strap (phy_addr_strap)
);

// File: tb/tb_tdm_phy_mux.sv
module tb_tdm_phy_mux;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, strb, mux_tx_en, mux_tx_data;
  logic       mux_crs, mux_rx_valid, mux_rx_data, mux_col, line_oe;
  logic       pad_col_in, pad_vld_in, pad_dat_in;
  logic [3:0] port_rx_act, port_rx_valid, port_rx_data, port_col;
  logic [3:0] port_tx_en, port_tx_data;
  logic [4:2] phy_addr_strap;

  tdm_phy_mux dut (.*);

  // fields: [23:20] rx act, [19:16] rx valid, [15:12] rx data, [11:8] col, [7:4] tx en, [3:0] tx data
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h000000, 24'hFFFFFF, 24'h12485A, 24'h8421A5,
    24'h0F60F9, 24'h00000F, 24'hC3963C, 24'h5A5A00
  };

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] m_en  = '0;
  logic [3:0] m_dat = '0;
  logic [23:0] cur;

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_line(input string req, input logic [3:0] exp);
    chk(req, "line {crs,valid,data,col}", {4'b0, mux_crs, mux_rx_valid, mux_rx_data, mux_col}, {4'b0, exp});
  endtask

  task automatic chk_tx(input string req);
    chk(req, "port_tx_en", {4'b0, port_tx_en}, {4'b0, m_en});
    chk(req, "port_tx_data", {4'b0, port_tx_data}, {4'b0, m_dat});
  endtask

  task automatic apply(input logic [23:0] v);
    port_rx_act   = v[23:20];
    port_rx_valid = v[19:16];
    port_rx_data  = v[15:12];
    port_col      = v[11:8];
  endtask

  task automatic hold_tx(input int p);
    mux_tx_en   = m_en[p];
    mux_tx_data = m_dat[p];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strb = 1'b0; mux_tx_en = 1'b0; mux_tx_data = 1'b0;
    pad_col_in = 1'b1; pad_vld_in = 1'b1; pad_dat_in = 1'b0;
    apply(24'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_line("R6", 4'h0);
    chk("R6", "line_oe in reset", {7'b0, line_oe}, 8'd0);
    chk_tx("R6");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "line_oe after release", {7'b0, line_oe}, 8'd1);
    chk("R7", "strap", {5'b0, phy_addr_strap}, 8'b011);
    pad_col_in = 1'b0; pad_vld_in = 1'b0; pad_dat_in = 1'b0;
    @(negedge clk);
    chk("R7", "strap after pad change", {5'b0, phy_addr_strap}, 8'b011);

    // align, then walk the vector table, one frame per vector
    apply(VEC[0]);
    strb = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        strb = 1'b0;
        cur = VEC[v];
        // R1 R4 R5: slot k carries port k
        chk_line("R1 R4 R5", {cur[20+k] | m_en[k], cur[16+k], cur[12+k], cur[8+k]});
        chk_tx("R3");
        mux_tx_en   = cur[4+k];
        mux_tx_data = cur[k];
        m_en[k]     = cur[4+k];
        m_dat[k]    = cur[k];
        if (k == 3 && v < NVEC - 1) apply(VEC[v+1]);
      end
    end

    // R2: strobe in slot 1, then held high
    @(negedge clk);                       // slot 0
    chk_tx("R3");
    hold_tx(0);
    @(negedge clk);                       // slot 1
    hold_tx(1);
    strb = 1'b1;
    port_rx_act = 4'b0000; port_rx_valid = 4'b1110;
    port_rx_data = 4'b0001; port_col = 4'b0100;
    @(negedge clk);                       // re-aligned slot 0
    chk_line("R2", {m_en[0], 1'b0, 1'b1, 1'b0});
    mux_tx_en = ~m_en[0]; mux_tx_data = ~m_dat[0];
    m_en[0] = ~m_en[0];   m_dat[0] = ~m_dat[0];
    @(negedge clk);                       // slot 1, strobe still high
    chk_tx("R2");
    chk_line("R2", {m_en[1], 1'b1, 1'b0, 1'b0});
    hold_tx(1);
    @(negedge clk);                       // slot 2
    chk_line("R2", {m_en[2], 1'b1, 1'b0, 1'b1});
    hold_tx(2);
    strb = 1'b0;
    @(negedge clk);                       // slot 3
    chk_line("R1", {m_en[3], 1'b1, 1'b0, 1'b0});
    hold_tx(3);

    // R6 R7: reset in the middle of traffic, pads move during reset
    @(negedge clk);
    rst_n = 1'b0;
    pad_col_in = 1'b1; pad_vld_in = 1'b0; pad_dat_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    m_en = '0; m_dat = '0;
    chk_line("R6", 4'h0);
    chk("R6", "line_oe in reset", {7'b0, line_oe}, 8'd0);
    chk_tx("R6");
    pad_col_in = 1'b0; pad_vld_in = 1'b1; pad_dat_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    pad_col_in = 1'b1; pad_vld_in = 1'b0; pad_dat_in = 1'b0;
    @(negedge clk);
    chk("R7", "strap at release", {5'b0, phy_addr_strap}, 8'b110);
    chk("R6", "line_oe after release", {7'b0, line_oe}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R7", "strap held", {5'b0, phy_addr_strap}, 8'b110);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule